// File: doc/BRIEF.md
# Group-One Integer ALU

This block evaluates the eight classic two-operand integer operations of a ModR/M-coded instruction group: add, add-with-carry, subtract, subtract-with-borrow, compare, and, or and exclusive-or. It also evaluates a bitwise test that sets flags and writes nothing. The operation comes from the 3-bit field in bits 5:3 of the instruction's ModR/M byte, unless the test input overrides it. Each operation runs at 8, 16 or 32 bits. The source operand may be replaced by its low 8 bits, sign-extended to the operand width, as the short-immediate forms require.

The execution stage gives the block the destination and source values, the current carry and auxiliary-carry flags, and a valid strobe. One clock later it returns the result, a write-enable for the destination, and the carry, zero, sign, parity, overflow and auxiliary flags. Operand fetch, address generation and memory access stay outside the block.

Top module: `grp1_alu`

## Requirements
- R1: The operation is `modrm_in[5:3]`: 0 add, 1 or, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 subtract, 6 xor, 7 compare. Bits 7:6 and 2:0 of `modrm_in` have no effect. When `test_in` is 1 the block runs the test operation whatever `modrm_in` holds.
- R2: Add yields dst+src. Add-with-carry yields dst+src+`cf_in`. For both, `cf_out` is the carry out of the top bit of the selected width.
- R3: Subtract and compare yield dst−src. Subtract-with-borrow yields dst−(src+`cf_in`). For all three, `cf_out` is the borrow out of the top bit of the selected width.
- R4: `of_out` is set when the signed result of the add or subtract at the selected width overflows. It is 0 for or, and, xor and test.
- R5: For arithmetic operations `af_out` is the carry or borrow out of bit 3. For or, and, xor and test, `af_out` repeats `af_in`.
- R6: Or, and, xor and test give `cf_out`=0 and `of_out`=0. For these operations the zero, sign and parity flags come from the bitwise result.
- R7: Compare and test update the flags but keep `wr_en_out` at 0. Every other operation raises `wr_en_out` together with `valid_out`.
- R8: `size_in` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. The result bits above the width read 0, and `zf_out` and `sf_out` use only the selected width.
- R9: With `imm8_in`=1 the source is `src_in[7:0]` sign-extended to the operand width, so a set bit 7 fills every upper bit with ones.
- R10: `pf_out` is 1 when the low 8 bits of the result hold an even number of ones.
- R11: Outputs appear on the clock edge after `valid_in` is sampled high. `valid_out` is the one-cycle delayed `valid_in`. After reset all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| modrm_in | input | 8 | Instruction byte; bits 5:3 select the operation |
| test_in | input | 1 | Run the non-writing test instead of the decoded operation |
| size_in | input | 2 | Operand width: 0=8, 1=16, 2/3=32 bits |
| imm8_in | input | 1 | Use sign-extended `src_in[7:0]` as the source |
| dst_in | input | 32 | Destination operand |
| src_in | input | 32 | Source operand |
| cf_in | input | 1 | Carry flag before the operation |
| af_in | input | 1 | Auxiliary flag before the operation |
| valid_out | output | 1 | Result and flags valid |
| wr_en_out | output | 1 | Write the result to the destination |
| result_out | output | 32 | Result, zero above the selected width |
| cf_out | output | 1 | Carry/borrow flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| pf_out | output | 1 | Even-parity flag of the low result byte |
| of_out | output | 1 | Signed overflow flag |
| af_out | output | 1 | Carry/borrow out of bit 3 |

## Verification
Hand-picked edge operands are checked against flag values worked out by hand: 0x7F+1, 0x80−1, a borrow through zero with carry-in, and an all-ones add with carry-in. These separate signed overflow from unsigned carry, and a nibble carry from a byte carry. A pseudo-random sweep covers every operation at every width with both carry-in values. The sweep is compared against a signed and unsigned integer model, which catches wrong width masking, a swapped carry or borrow sense, and a wrong operation code. Separate scenarios set the ModR/M bits outside the field and turn on the test override, to show that the unused bits have no effect. They also negate carry-in, to show that it matters only for the carry forms. Further scenarios use immediates with bit 7 set at 16 and 32 bits, to show that sign extension fills the upper bits.

// File: rtl/grp1_alu_pkg.sv
package grp1_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_OR  = 3'd1,
      OP_ADC = 3'd2,
      OP_SBB = 3'd3,
      OP_AND = 3'd4,
      OP_SUB = 3'd5,
      OP_XOR = 3'd6,
      OP_CMP = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } alu_size_e;

   typedef struct packed {
      logic cf;
      logic zf;
      logic sf;
      logic pf;
      logic of;
      logic af;
   } alu_flags_t;

   localparam int unsigned LANE_W = 8;

   // number of active byte lanes for a size code
   function automatic int unsigned lanes_for(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/grp1_operand_prep.sv
module grp1_operand_prep
   import grp1_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 8
) (
   input  logic [1:0]        size_i,
   input  logic              imm_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [DATA_W-1:0] mask_o,
   output logic [DATA_W-1:0] dst_o,
   output logic [DATA_W-1:0] src_o
);
   localparam int unsigned N_LANES = DATA_W / LANE_W;

   logic [DATA_W-1:0] src_sel;

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      assign mask_o[g*LANE_W +: LANE_W] =
         (g < lanes_for(size_i)) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
   end

   assign src_sel = imm_i ? {{(DATA_W-IMM_W){src_i[IMM_W-1]}}, src_i[IMM_W-1:0]}
                          : src_i;
   assign dst_o   = dst_i & mask_o;
   assign src_o   = src_sel & mask_o;

endmodule

// File: rtl/grp1_arith_unit.sv
module grp1_arith_unit
   import grp1_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [1:0]        size_i,
   input  logic              sub_i,
   input  logic              cin_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cf_o,
   output logic              of_o,
   output logic              af_o
);
   localparam int unsigned EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] a_x, b_x, c_x, t_x;
   logic             a_top, b_top, r_top;

   assign a_x = {1'b0, a_i};
   assign b_x = {1'b0, b_i};
   assign c_x = {{DATA_W{1'b0}}, cin_i};
   assign t_x = sub_i ? (a_x - b_x - c_x) : (a_x + b_x + c_x);
   assign res_o = t_x[DATA_W-1:0] & mask_i;

   always_comb begin
      case (size_i)
         SZ_BYTE: begin
            cf_o  = t_x[LANE_W];
            a_top = a_i[LANE_W-1];
            b_top = b_i[LANE_W-1];
            r_top = t_x[LANE_W-1];
         end
         SZ_HALF: begin
            cf_o  = t_x[2*LANE_W];
            a_top = a_i[2*LANE_W-1];
            b_top = b_i[2*LANE_W-1];
            r_top = t_x[2*LANE_W-1];
         end
         default: begin
            cf_o  = t_x[DATA_W];
            a_top = a_i[DATA_W-1];
            b_top = b_i[DATA_W-1];
            r_top = t_x[DATA_W-1];
         end
      endcase
   end

   assign of_o = sub_i ? ((a_top != b_top) && (r_top != a_top))
                       : ((a_top == b_top) && (r_top != a_top));
   assign af_o = a_x[4] ^ b_x[4] ^ t_x[4];

endmodule

// File: rtl/grp1_logic_unit.sv
module grp1_logic_unit
   import grp1_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);
   always_comb begin
      case (op_i)
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         default: res_o = a_i & b_i;
      endcase
   end
endmodule

// File: rtl/grp1_alu.sv
module grp1_alu
   import grp1_alu_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IMM_W   = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [7:0]        modrm_in,
   input  logic              test_in,
   input  logic [1:0]        size_in,
   input  logic              imm8_in,
   input  logic [DATA_W-1:0] dst_in,
   input  logic [DATA_W-1:0] src_in,
   input  logic              cf_in,
   input  logic              af_in,
   output logic              valid_out,
   output logic              wr_en_out,
   output logic [DATA_W-1:0] result_out,
   output logic              cf_out,
   output logic              zf_out,
   output logic              sf_out,
   output logic              pf_out,
   output logic              of_out,
   output logic              af_out
);
   initial begin
      assert (DATA_W == 4 * LANE_W) else $error("grp1_alu: DATA_W must be 32");
      assert (IMM_W == LANE_W)      else $error("grp1_alu: IMM_W must be 8");
   end

   alu_op_e           op_fld, op_eff;
   logic              is_logic, is_sub, use_cin, wr_c;
   logic [DATA_W-1:0] mask, a_m, b_m, arith_res, logic_res, res_c;
   logic              a_cf, a_of, a_af;
   alu_flags_t        flg_c;
   logic              unused_modrm;

   assign unused_modrm = ^{modrm_in[7:6], modrm_in[2:0]};
   assign op_fld   = alu_op_e'(modrm_in[5:3]);
   assign op_eff   = test_in ? OP_AND : op_fld;
   assign is_logic = (op_eff == OP_OR) || (op_eff == OP_AND) || (op_eff == OP_XOR);
   assign is_sub   = (op_eff == OP_SUB) || (op_eff == OP_SBB) || (op_eff == OP_CMP);
   assign use_cin  = (op_eff == OP_ADC) || (op_eff == OP_SBB);
   assign wr_c     = !test_in && (op_fld != OP_CMP);

   grp1_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) prep_i (
      .size_i(size_in), .imm_i(imm8_in), .dst_i(dst_in), .src_i(src_in),
      .mask_o(mask), .dst_o(a_m), .src_o(b_m)
   );

   grp1_arith_unit #(.DATA_W(DATA_W)) arith_i (
      .size_i(size_in), .sub_i(is_sub), .cin_i(use_cin & cf_in), .mask_i(mask),
      .a_i(a_m), .b_i(b_m), .res_o(arith_res),
      .cf_o(a_cf), .of_o(a_of), .af_o(a_af)
   );

   grp1_logic_unit #(.DATA_W(DATA_W)) logic_i (
      .op_i(op_eff), .a_i(a_m), .b_i(b_m), .res_o(logic_res)
   );

   assign res_c = is_logic ? logic_res : arith_res;

   always_comb begin
      flg_c.cf = is_logic ? 1'b0  : a_cf;
      flg_c.of = is_logic ? 1'b0  : a_of;
      flg_c.af = is_logic ? af_in : a_af;
      flg_c.zf = (res_c == '0);
      flg_c.pf = ~^res_c[LANE_W-1:0];
      case (size_in)
         SZ_BYTE: flg_c.sf = res_c[LANE_W-1];
         SZ_HALF: flg_c.sf = res_c[2*LANE_W-1];
         default: flg_c.sf = res_c[DATA_W-1];
      endcase
   end

   alu_flags_t flg_q;

   if (REG_OUT) begin : g_reg
      logic              vld_q, wr_q;
      logic [DATA_W-1:0] res_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            wr_q  <= 1'b0;
            res_q <= '0;
            flg_q <= '0;
         end else begin
            vld_q <= valid_in;
            wr_q  <= valid_in & wr_c;
            if (valid_in) begin
               res_q <= res_c;
               flg_q <= flg_c;
            end
         end
      end

      assign valid_out  = vld_q;
      assign wr_en_out  = wr_q;
      assign result_out = res_q;

      // R7: compare never writes back
      p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && !test_in && modrm_in[5:3] == 3'd7) |=> !wr_en_out);
      // R7: test never writes back
      p_test_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && test_in) |=> !wr_en_out);
      // R6: logical ops clear carry and overflow
      p_logic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && (test_in || modrm_in[5:3] inside {3'd1, 3'd4, 3'd6}))
         |=> (!cf_out && !of_out));
      // R5: logical ops keep the auxiliary flag
      p_af_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && (test_in || modrm_in[5:3] inside {3'd1, 3'd4, 3'd6}))
         |=> (af_out == $past(af_in)));
      // R8: byte results carry nothing above bit 7
      p_byte_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_in && size_in == 2'd0) |=> (result_out[DATA_W-1:LANE_W] == '0));
      // R11: output valid follows input valid by one cycle
      p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
         valid_in |=> valid_out);
      // R11: no write without a valid result
      p_wr_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en_out |-> valid_out);
   end else begin : g_comb
      assign valid_out  = valid_in;
      assign wr_en_out  = valid_in & wr_c;
      assign result_out = res_c;
      assign flg_q      = flg_c;
   end

   assign cf_out = flg_q.cf;
   assign zf_out = flg_q.zf;
   assign sf_out = flg_q.sf;
   assign pf_out = flg_q.pf;
   assign of_out = flg_q.of;
   assign af_out = flg_q.af;

endmodule

// File: tb/grp1_alu_tb_top.sv
`timescale 1ns/1ps
module grp1_alu_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [7:0]  modrm_in = '0;
   logic        test_in = 1'b0;
   logic [1:0]  size_in = '0;
   logic        imm8_in = 1'b0;
   logic [31:0] dst_in = '0;
   logic [31:0] src_in = '0;
   logic        cf_in = 1'b0;
   logic        af_in = 1'b0;
   logic        valid_out, wr_en_out;
   logic [31:0] result_out;
   logic        cf_out, zf_out, sf_out, pf_out, of_out, af_out;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #2.5 clk = ~clk;

   grp1_alu dut_i (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .modrm_in(modrm_in),
      .test_in(test_in), .size_in(size_in), .imm8_in(imm8_in),
      .dst_in(dst_in), .src_in(src_in), .cf_in(cf_in), .af_in(af_in),
      .valid_out(valid_out), .wr_en_out(wr_en_out), .result_out(result_out),
      .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out), .pf_out(pf_out),
      .of_out(of_out), .af_out(af_out)
   );

   // flag vector order: {cf, zf, sf, pf, of, af}
   function automatic logic [5:0] out_flags();
      return {cf_out, zf_out, sf_out, pf_out, of_out, af_out};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] r_exp, input logic wr_exp,
                        input logic [5:0] f_exp);
      n_checks++;
      if (!valid_out || result_out !== r_exp || wr_en_out !== wr_exp ||
          out_flags() !== f_exp) begin
         n_fail++;
         $display("FAIL %s %s: actual res=%h wr=%b flags=%b vld=%b expected res=%h wr=%b flags=%b vld=1",
                  req, what, result_out, wr_en_out, out_flags(), valid_out,
                  r_exp, wr_exp, f_exp);
      end
   endtask

   // independent integer model of the requirements
   task automatic model(input logic [2:0] op, input logic tst, input logic [1:0] sz,
                        input logic imm, input logic [31:0] d_in, input logic [31:0] s_in,
                        input logic c_in, input logic a_in,
                        output logic [31:0] r, output logic wr, output logic [5:0] f);
      int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      longint span = longint'(1) << w;
      longint mask = span - 1;
      longint half = span / 2;
      longint d = longint'(d_in) & mask;
      longint s, sd, ss, sr, t, c, rr;
      logic cf, of, af;
      int ones = 0;
      logic [2:0] eop = tst ? 3'd4 : op;
      if (imm) begin
         longint se = longint'($signed(s_in[7:0]));
         s = se & mask;
      end else s = longint'(s_in) & mask;
      sd = (d >= half) ? d - span : d;
      ss = (s >= half) ? s - span : s;
      c  = (eop == 3'd2 || eop == 3'd3) ? longint'(c_in) : 0;
      af = a_in; cf = 0; of = 0;
      case (eop)
         3'd0, 3'd2: begin
            t = d + s + c; rr = t & mask; cf = (t > mask);
            sr = sd + ss + c; of = (sr >= half) || (sr < -half);
            af = ((d & 15) + (s & 15) + c) > 15;
         end
         3'd3, 3'd5, 3'd7: begin
            t = d - s - c; rr = t & mask; cf = (t < 0);
            sr = sd - ss - c; of = (sr >= half) || (sr < -half);
            af = (d & 15) < ((s & 15) + c);
         end
         3'd1: rr = d | s;
         3'd6: rr = d ^ s;
         default: rr = d & s;
      endcase
      for (int i = 0; i < 8; i++) ones += int'(rr[i]);
      r  = rr[31:0];
      wr = !(tst || op == 3'd7);
      f  = {cf, rr == 0, rr >= half, (ones % 2) == 0, of, af};
   endtask

   // drive at a negedge, check at the following negedge
   task automatic run_op(input logic [7:0] mrm, input logic tst, input logic [1:0] sz,
                         input logic imm, input logic [31:0] d, input logic [31:0] s,
                         input logic c, input logic a);
      valid_in = 1'b1; modrm_in = mrm; test_in = tst; size_in = sz;
      imm8_in = imm; dst_in = d; src_in = s; cf_in = c; af_in = a;
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   task automatic run_model(input string req, input string what, input logic [7:0] mrm,
                            input logic tst, input logic [1:0] sz, input logic imm,
                            input logic [31:0] d, input logic [31:0] s,
                            input logic c, input logic a);
      logic [31:0] r; logic wr; logic [5:0] f;
      model(mrm[5:3], tst, sz, imm, d, s, c, a, r, wr, f);
      run_op(mrm, tst, sz, imm, d, s, c, a);
      check(req, what, r, wr, f);
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] x);
      logic [31:0] y = x;
      y ^= y << 13; y ^= y >> 17; y ^= y << 5;
      return y;
   endfunction

   task automatic t_reset();
      // R11: reset state
      n_checks++;
      if (valid_out !== 1'b0 || wr_en_out !== 1'b0 || result_out !== '0 ||
          out_flags() !== 6'b0) begin
         n_fail++;
         $display("FAIL R11 reset: actual vld=%b wr=%b res=%h flags=%b expected all zero",
                  valid_out, wr_en_out, result_out, out_flags());
      end
   endtask

   task automatic t_boundaries();
      // R4 R5 R10: 0x7F+1 byte -> 0x80, OF, AF, SF, odd parity
      run_op(8'h00, 0, 2'd0, 0, 32'h7F, 32'h01, 0, 0);
      check("R4", "7F+1", 32'h80, 1, 6'b001011);
      // R3 R4: 0x80-1 byte -> 0x7F, OF, AF
      run_op(8'h28, 0, 2'd0, 0, 32'h80, 32'h01, 0, 0);
      check("R3", "80-1", 32'h7F, 1, 6'b000011);
      // R3: sbb 0-0-1 halfword -> FFFF, borrow, SF, PF, AF
      run_op(8'h18, 0, 2'd1, 0, 32'h0, 32'h0, 1, 0);
      check("R3", "sbb borrow-in", 32'hFFFF, 1, 6'b101101);
      // R2: adc FFFFFFFF+0+1 -> 0, carry, ZF, PF, AF
      run_op(8'h10, 0, 2'd2, 0, 32'hFFFF_FFFF, 32'h0, 1, 0);
      check("R2", "adc wrap", 32'h0, 1, 6'b110101);
   endtask

   task automatic t_carry_sense();
      // R2: plain add ignores cf_in
      run_model("R2", "add ignores cf", 8'h00, 0, 2'd1, 0, 32'h1234, 32'h0FFF, 1, 0);
      // R3: plain sub ignores cf_in
      run_model("R3", "sub ignores cf", 8'h28, 0, 2'd0, 0, 32'h10, 32'h10, 1, 0);
   endtask

   task automatic t_logic();
      // R6 R5: logic clears CF/OF and passes af_in through
      run_model("R6", "or", 8'h08, 0, 2'd2, 0, 32'h8000_0000, 32'h1, 1, 1);
      run_model("R6", "and zero", 8'h20, 0, 2'd0, 0, 32'hF0, 32'h0F, 1, 1);
      run_model("R5", "xor af hold", 8'h30, 0, 2'd1, 0, 32'hAAAA, 32'h5555, 0, 1);
      // R10: parity of low byte only
      run_op(8'h08, 0, 2'd1, 0, 32'h0100, 32'h0003, 0, 0);
      check("R10", "parity low byte", 32'h0103, 1, 6'b000100);
   endtask

   task automatic t_no_write();
      // R7: compare sets flags like subtract, no write
      run_op(8'h38, 0, 2'd0, 0, 32'h05, 32'h05, 0, 0);
      check("R7", "cmp equal", 32'h0, 0, 6'b010100);
      // R7: test ignores the op field and writes nothing
      run_model("R7", "test", 8'h00, 1, 2'd2, 0, 32'hFF00_0000, 32'h8000_00FF, 0, 1);
   endtask

   task automatic t_modrm_bits();
      // R1: outer modrm bits have no effect (sub with 0xC7 around the field)
      run_model("R1", "modrm outer bits", 8'hEF, 0, 2'd1, 0, 32'h0003, 32'h0005, 0, 0);
      run_op(8'hC7 | 8'h28, 0, 2'd0, 0, 32'h03, 32'h05, 0, 0);
      check("R1", "sub 3-5 outer bits", 32'hFE, 1, 6'b101001);
   endtask

   task automatic t_sizes();
      // R8: upper bits zero, flags at width
      run_op(8'h00, 0, 2'd0, 0, 32'hFFFF_FF80, 32'hFFFF_FF80, 0, 0);
      check("R8", "byte add upper ignored", 32'h00, 1, 6'b110110);
      run_model("R8", "size 3 is 32", 8'h00, 0, 2'd3, 0, 32'h7FFF_FFFF, 32'h1, 0, 0);
      run_model("R8", "half sub", 8'h28, 0, 2'd1, 0, 32'hABCD_0000, 32'h0001_0001, 0, 0);
   endtask

   task automatic t_imm();
      // R9: 0x80 sign-extends to all ones above bit 7
      run_op(8'h00, 0, 2'd1, 1, 32'h0000, 32'h0000_1280, 0, 0);
      check("R9", "imm sext 16", 32'hFF80, 1, 6'b001000);
      run_op(8'h08, 0, 2'd2, 1, 32'h0, 32'h0000_00FF, 0, 0);
      check("R9", "imm sext 32", 32'hFFFF_FFFF, 1, 6'b001100);
      run_model("R9", "imm positive", 8'h28, 0, 2'd2, 1, 32'h100, 32'hFFFF_FF7F, 0, 0);
   endtask

   task automatic t_sweep();
      // R1 R2 R3 R4 R5 R6 R8 R10: every op, width and carry-in
      for (int op = 0; op < 8; op++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 6; k++) begin
               logic [31:0] d, s;
               rng = next_rng(rng); d = rng;
               rng = next_rng(rng); s = rng;
               if (k == 0) s = d;
               run_model("R1", "sweep", {2'b00, 3'(op), 3'b000}, 0, 2'(sz), k[0],
                         d, s, k[1], k[2]);
            end
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_boundaries();
      t_carry_sense();
      t_logic();
      t_no_write();
      t_modrm_bits();
      t_sizes();
      t_imm();
      t_sweep();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule